// File: doc/BRIEF.md
# Field-Synchronized Double-Buffered Base Registers

This block is the base-address register bank of a video capture engine. It holds one memory base address for the even field and one for the odd field. Software writes either base over a simple register bus addressed by byte offset. A write never changes the address the capture side is using. The value goes into a pending copy, and a status flag shows that a change is waiting.

The capture side pulses a strobe on the first captured data of each field. When that strobe arrives with a change waiting, every pending base is copied into its active register in the same cycle and the flag clears. A new base therefore takes effect at a clean field boundary and never partway through a field. The active bases drive dedicated output ports for the address generator. A read of a base offset returns the pending copy, so software reads back what it last wrote.

Sequencing is done by a two-state machine. In `ST_SYNCED`, pending and active agree and the flag is clear. In `ST_STAGED`, a write is waiting and the flag is set. The transitions are as follows. `T_STAGE` goes from `ST_SYNCED` to `ST_STAGED` on a base write without a strobe. `T_FLUSH` goes from `ST_SYNCED` to `ST_SYNCED` on a base write together with a strobe, and it commits. `T_COMMIT` goes from `ST_STAGED` to `ST_SYNCED` on a strobe, and it commits. `T_HOLD` keeps the current state in all other cases.

Top module: `fbr_base_regs`

## Requirements
- R1: After reset, both active outputs are 0, reads of offsets 18h and 1Ch return 0, and status bit 16 at offset 08h is 0.
- R2: The even base is written and read at byte offset 18h and the odd base at 1Ch. A read of either offset returns the pending value. A read of offset 08h returns the flag in bit 16 with all other bits 0. A read of any other offset returns 0.
- R3: Bits [4:0] of a written base are forced to 0 whatever the bus supplies, so pending and active values are always 32-byte aligned.
- R4: A write to 18h or 1Ch without a field-start strobe leaves both active outputs unchanged and sets status bit 16 from the next cycle onward.
- R5: A field-start strobe while status bit 16 is set copies both pending values into the active outputs in the same clock edge and clears bit 16.
- R6: A base write in the same cycle as a field-start strobe commits the newly written value together with the other pending base, and bit 16 ends up clear.
- R7: A field-start strobe while no write is pending leaves both active outputs unchanged and bit 16 clear.
- R8: Writes to any offset other than 18h and 1Ch, including 08h, change no pending value, no active value and no flag.
- R9: The active outputs change only on a clock edge at which the field-start strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte offset for read and write |
| bus_wr | input | 1 | Write enable for bus_wdata at bus_addr |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| field_start | input | 1 | Pulse on the first captured data of a field |
| active_even_base | output | 32 | Base address in use for even fields |
| active_odd_base | output | 32 | Base address in use for odd fields |

## Verification
The assertions assume that `field_start` and `bus_wr` are synchronous single-cycle qualifiers. They also assume that the bus carries one write per cycle and that a write's data and offset are stable over the cycle in which `bus_wr` is high. The stimulus changes every input only on the falling clock edge. It issues at most one write per cycle, and it mixes writes to the base offsets, the status offset and unused offsets with strobes that fall on empty, staged and same-cycle-write states. Data words are random and include nonzero low bits, so the alignment masking is exercised on every write.

// File: rtl/fbr_pkg.sv
package fbr_pkg;

    // number of field base registers (even, odd)
    localparam int NUM_FIELDS = 2;

    typedef enum logic [0:0] {
        ST_SYNCED = 1'b0,
        ST_STAGED = 1'b1
    } fbr_state_e;

endpackage

// File: rtl/fbr_bus_decode.sv
module fbr_bus_decode #(
    parameter int                ADDR_W     = 8,
    parameter int                NF         = 2,
    parameter logic [ADDR_W-1:0] FIELD0_OFS = 8'h18,
    parameter int                STRIDE     = 4,
    parameter logic [ADDR_W-1:0] STAT_OFS   = 8'h08
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    output logic [NF-1:0]     wr_sel,
    output logic [NF-1:0]     rd_sel,
    output logic              rd_stat,
    output logic              base_wr
);

    genvar g;
    generate
        for (g = 0; g < NF; g++) begin : g_field
            localparam logic [ADDR_W-1:0] OFS = FIELD0_OFS + ADDR_W'(g * STRIDE);
            assign rd_sel[g] = (bus_addr == OFS);
            assign wr_sel[g] = bus_wr && (bus_addr == OFS);
        end
    endgenerate

    assign rd_stat = (bus_addr == STAT_OFS);
    assign base_wr = |wr_sel;

endmodule

// File: rtl/fbr_pending_bank.sv
module fbr_pending_bank #(
    parameter int DATA_W     = 32,
    parameter int ALIGN_BITS = 5,
    parameter int NF         = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NF-1:0]             wr_sel,
    input  logic [DATA_W-1:0]         wdata,
    output logic [NF-1:0][DATA_W-1:0] pend_q,
    output logic [NF-1:0][DATA_W-1:0] pend_d
);

    localparam logic [DATA_W-1:0] ALIGN_MASK = ~((DATA_W'(1) << ALIGN_BITS) - DATA_W'(1));

    logic [DATA_W-1:0] wdata_aligned;
    assign wdata_aligned = wdata & ALIGN_MASK;

    genvar g;
    generate
        for (g = 0; g < NF; g++) begin : g_reg
            assign pend_d[g] = wr_sel[g] ? wdata_aligned : pend_q[g];

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pend_q[g] <= '0;
                end else begin
                    pend_q[g] <= pend_d[g];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/fbr_commit_fsm.sv
module fbr_commit_fsm
    import fbr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic base_wr,
    input  logic field_start,
    output logic commit,
    output logic status_flag
);

    fbr_state_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SYNCED: begin
                if (base_wr && !field_start) begin
                    state_d = ST_STAGED;      // T_STAGE
                end else begin
                    state_d = ST_SYNCED;      // T_FLUSH or T_HOLD
                end
            end
            ST_STAGED: begin
                if (field_start) begin
                    state_d = ST_SYNCED;      // T_COMMIT
                end else begin
                    state_d = ST_STAGED;      // T_HOLD
                end
            end
            default: state_d = ST_SYNCED;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_SYNCED;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        commit      = 1'b0;
        status_flag = 1'b0;
        unique case (state_q)
            ST_SYNCED: begin
                commit = field_start && base_wr;   // T_FLUSH
            end
            ST_STAGED: begin
                status_flag = 1'b1;
                commit      = field_start;         // T_COMMIT
            end
            default: begin
                commit      = 1'b0;
                status_flag = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/fbr_active_bank.sv
module fbr_active_bank #(
    parameter int DATA_W = 32,
    parameter int NF     = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      commit,
    input  logic [NF-1:0][DATA_W-1:0] pend_d,
    output logic [NF-1:0][DATA_W-1:0] act_q
);

    genvar g;
    generate
        for (g = 0; g < NF; g++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    act_q[g] <= '0;
                end else if (commit) begin
                    act_q[g] <= pend_d[g];
                end
            end
        end
    endgenerate

endmodule

// File: rtl/fbr_base_regs.sv
module fbr_base_regs
    import fbr_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 32,
    parameter int                ALIGN_BITS = 5,
    parameter int                FLAG_BIT   = 16,
    parameter logic [ADDR_W-1:0] FIELD0_OFS = 8'h18,
    parameter int                STRIDE     = 4,
    parameter logic [ADDR_W-1:0] STAT_OFS   = 8'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              field_start,
    output logic [DATA_W-1:0] active_even_base,
    output logic [DATA_W-1:0] active_odd_base
);

    localparam int NF = NUM_FIELDS;

    logic [NF-1:0]             wr_sel;
    logic [NF-1:0]             rd_sel;
    logic                      rd_stat;
    logic                      base_wr;
    logic                      commit;
    logic                      status_flag;
    logic [NF-1:0][DATA_W-1:0] pend_q;
    logic [NF-1:0][DATA_W-1:0] pend_d;
    logic [NF-1:0][DATA_W-1:0] act_q;

    fbr_bus_decode #(
        .ADDR_W    (ADDR_W),
        .NF        (NF),
        .FIELD0_OFS(FIELD0_OFS),
        .STRIDE    (STRIDE),
        .STAT_OFS  (STAT_OFS)
    ) decode_i (
        .bus_addr(bus_addr),
        .bus_wr  (bus_wr),
        .wr_sel  (wr_sel),
        .rd_sel  (rd_sel),
        .rd_stat (rd_stat),
        .base_wr (base_wr)
    );

    fbr_pending_bank #(
        .DATA_W    (DATA_W),
        .ALIGN_BITS(ALIGN_BITS),
        .NF        (NF)
    ) pending_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_sel(wr_sel),
        .wdata (bus_wdata),
        .pend_q(pend_q),
        .pend_d(pend_d)
    );

    fbr_commit_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_wr    (base_wr),
        .field_start(field_start),
        .commit     (commit),
        .status_flag(status_flag)
    );

    fbr_active_bank #(
        .DATA_W(DATA_W),
        .NF    (NF)
    ) active_i (
        .clk   (clk),
        .rst_n (rst_n),
        .commit(commit),
        .pend_d(pend_d),
        .act_q (act_q)
    );

    // read mux: pending copies at base offsets, flag at status offset
    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < NF; i++) begin
            if (rd_sel[i]) begin
                bus_rdata = pend_q[i];
            end
        end
        if (rd_stat) begin
            bus_rdata[FLAG_BIT] = status_flag;
        end
    end

    assign active_even_base = act_q[0];
    assign active_odd_base  = act_q[1];

endmodule

// File: rtl/fbr_base_regs_chk.sv
module fbr_base_regs_chk #(
    parameter int DATA_W     = 32,
    parameter int ALIGN_BITS = 5
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         field_start,
    input logic                         base_wr,
    input logic                         status_flag,
    input logic [1:0][DATA_W-1:0]       pend_q,
    input logic [DATA_W-1:0]            active_even_base,
    input logic [DATA_W-1:0]            active_odd_base
);

    // R3: stored values keep the alignment bits clear
    a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (active_even_base[ALIGN_BITS-1:0] == '0) && (active_odd_base[ALIGN_BITS-1:0] == '0)
        && (pend_q[0][ALIGN_BITS-1:0] == '0) && (pend_q[1][ALIGN_BITS-1:0] == '0));

    // R4: a staged write raises the flag
    a_r4_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (base_wr && !field_start) |=> status_flag);

    // R5: strobe always leaves the flag clear
    a_r5_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |=> !status_flag);

    // R5: staged values are copied together
    a_r5_commit_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (field_start && status_flag && !base_wr) |=>
        (active_even_base == $past(pend_q[0])) && (active_odd_base == $past(pend_q[1])));

    // R7: strobe with nothing pending changes nothing
    a_r7_idle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (field_start && !status_flag && !base_wr) |=>
        ($stable(active_even_base) && $stable(active_odd_base) && !status_flag));

    // R9: active outputs hold between strobes
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !field_start |=> ($stable(active_even_base) && $stable(active_odd_base)));

endmodule

bind fbr_base_regs fbr_base_regs_chk #(
    .DATA_W    (DATA_W),
    .ALIGN_BITS(ALIGN_BITS)
) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .field_start     (field_start),
    .base_wr         (base_wr),
    .status_flag     (status_flag),
    .pend_q          (pend_q),
    .active_even_base(active_even_base),
    .active_odd_base (active_odd_base)
);

// File: tb/fbr_base_regs_tb_top.sv
module fbr_base_regs_tb_top;

    localparam logic [7:0] OFS_EVEN = 8'h18;
    localparam logic [7:0] OFS_ODD  = 8'h1C;
    localparam logic [7:0] OFS_STAT = 8'h08;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        field_start = 1'b0;
    logic [31:0] active_even_base;
    logic [31:0] active_odd_base;

    int total = 0;
    int bad   = 0;

    // model state
    logic [31:0] m_pe = '0, m_po = '0, m_ae = '0, m_ao = '0;
    logic        m_flag = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    fbr_base_regs dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .bus_addr        (bus_addr),
        .bus_wr          (bus_wr),
        .bus_wdata       (bus_wdata),
        .bus_rdata       (bus_rdata),
        .field_start     (field_start),
        .active_even_base(active_even_base),
        .active_odd_base (active_odd_base)
    );

    function automatic logic [31:0] align32(input logic [31:0] v);
        return v & 32'hFFFF_FFE0;
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        if (a == OFS_EVEN) return m_pe;
        if (a == OFS_ODD)  return m_po;
        if (a == OFS_STAT) return {15'b0, m_flag, 16'b0};
        return 32'h0;
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // read at negedge phase, no clock edge involved
    task automatic read_chk(input string tag, input logic [7:0] a);
        bus_wr   = 1'b0;
        bus_addr = a;
        #1;
        check(tag, $sformatf("read %h", a), bus_rdata, exp_read(a));
    endtask

    task automatic check_all(input string tag);
        check(tag, "active even", active_even_base, m_ae);
        check(tag, "active odd",  active_odd_base,  m_ao);
        read_chk(tag, OFS_EVEN);
        read_chk(tag, OFS_ODD);
        read_chk(tag, OFS_STAT);
    endtask

    // one clock: drive at negedge, model on posedge, back at next negedge
    task automatic step(input logic wr, input logic [7:0] a,
                        input logic [31:0] d, input logic strobe);
        logic        wb;
        logic [31:0] npe, npo;
        bus_wr      = wr;
        bus_addr    = a;
        bus_wdata   = d;
        field_start = strobe;
        @(posedge clk);
        wb  = wr && (a == OFS_EVEN || a == OFS_ODD);
        npe = (wr && a == OFS_EVEN) ? align32(d) : m_pe;
        npo = (wr && a == OFS_ODD)  ? align32(d) : m_po;
        if (strobe && (m_flag || wb)) begin
            m_ae   = npe;
            m_ao   = npo;
            m_flag = 1'b0;
        end else if (wb) begin
            m_flag = 1'b1;
        end
        m_pe = npe;
        m_po = npo;
        @(negedge clk);
        bus_wr      = 1'b0;
        field_start = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] seed_v;
        seed_v = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        // R1: reset state
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R7: strobe with nothing pending
        step(1'b0, 8'h00, 32'h0, 1'b1);
        check_all("R7");

        // R3 R4: write even with low bits set, active unchanged, flag set
        step(1'b1, OFS_EVEN, 32'h1234_567F, 1'b0);
        check("R3", "pending even aligned", exp_read(OFS_EVEN), 32'h1234_5660);
        check_all("R4");
        step(1'b1, OFS_ODD, 32'hABCD_EF1F, 1'b0);
        check_all("R4");

        // R8: writes to status and unused offsets ignored
        step(1'b1, OFS_STAT, 32'hFFFF_FFFF, 1'b0);
        check_all("R8");
        step(1'b1, 8'h20, 32'hFFFF_FFFF, 1'b0);
        check_all("R8");
        read_chk("R2", 8'h20);

        // R9: hold without strobe
        step(1'b0, 8'h00, 32'h0, 1'b0);
        check_all("R9");

        // R5: commit both
        step(1'b0, 8'h00, 32'h0, 1'b1);
        check("R5", "even committed", active_even_base, 32'h1234_5660);
        check("R5", "odd committed",  active_odd_base,  32'hABCD_EF00);
        check_all("R5");

        // R6: write together with strobe from synced
        step(1'b1, OFS_ODD, 32'h0000_4321, 1'b1);
        check("R6", "odd same-cycle", active_odd_base, 32'h0000_4320);
        check_all("R6");

        // R6: write together with strobe from staged
        step(1'b1, OFS_EVEN, 32'h0F0F_0F0F, 1'b0);
        step(1'b1, OFS_ODD,  32'h7777_7777, 1'b1);
        check_all("R6");

        // R8 from synced: status write must not set the flag
        step(1'b1, OFS_STAT, 32'h0001_0000, 1'b0);
        check_all("R8");

        // R8 R9: random mix
        for (int n = 0; n < 400; n++) begin
            logic [2:0]  pick;
            logic [7:0]  a;
            pick = 3'($urandom_range(0, 5));
            case (pick)
                3'd0, 3'd1: a = OFS_EVEN;
                3'd2, 3'd3: a = OFS_ODD;
                3'd4:       a = OFS_STAT;
                default:    a = 8'($urandom);
            endcase
            step(($urandom_range(0, 3) != 0), a, $urandom,
                 ($urandom_range(0, 3) == 0));
            check_all("R9");
            read_chk("R2", 8'($urandom));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule